// File: doc/BRIEF.md
# Maskable Sticky Interrupt Controller

This block gathers single-cycle event pulses from a cell receiver and from other status sources into a row of sticky status bits. Each bit stays set once it sees its event, until software reads the status port. The read returns the latched bits and clears them in the same cycle. An event that lands in the same cycle as the clearing read is kept for the next read, so no event is lost.

An active-low interrupt line is formed from the sticky bits. Three things gate it: a global enable, a per-source enable vector, and a cell-error-only mode. In cell-error-only mode the per-source enables are overridden. Only the sources named in a fixed cell-error set can then pull the line low. That set covers a bad header checksum, a cell shorter than 53 bytes and a received symbol error. Normal operation is global enable on and cell-error-only mode off.

The interrupt line is registered. It moves one clock after the sticky state it reflects.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: While reset is high, at the next clock edge `irq_n_o` is 1, `rd_vld_o` is 0 and `rd_data_o` is all zeros.
- R2: An event pulse on `evt_i[i]` sets sticky bit i at that clock edge, whatever the values of `glb_en_i`, `cell_only_i` and `src_en_i`. The bit is observed through a later read.
- R3: A read strobe `rd_i` sampled at an edge puts the sticky bits held before that edge on `rd_data_o`, with `rd_vld_o` high, in the following cycle. The same edge clears every sticky bit that has no event in that cycle.
- R4: An event arriving in the same cycle as a read strobe is not part of that read's data. It stays set and is returned by the next read.
- R5: With `glb_en_i`=1 and `cell_only_i`=0, a set sticky bit whose `src_en_i` bit is 1 drives `irq_n_o` to 0 one clock after the bit becomes set.
- R6: With `glb_en_i`=0, `irq_n_o` stays 1 whatever sticky bits are set.
- R7: In normal mode, a sticky bit whose `src_en_i` bit is 0 does not pull `irq_n_o` low.
- R8: With `glb_en_i`=1 and `cell_only_i`=1, only sticky bits inside `CELL_ERR_SET` can drive `irq_n_o` low, and `src_en_i` is ignored. By default `CELL_ERR_SET` covers bit 0 (bad header checksum), bit 1 (short cell) and bit 2 (symbol error). All other bits are blocked in this mode.
- R9: `irq_n_o` returns to 1 one clock after no enabled sticky bit remains set, for example one clock after the clearing read edge.
- R10: Several events in the same cycle are all latched and all returned together by one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| glb_en_i | input | 1 | Global interrupt enable |
| cell_only_i | input | 1 | Cell-error-only interrupt mode |
| src_en_i | input | NUM_SRC | Per-source interrupt enable, 1 = allowed |
| rd_i | input | 1 | Status read strobe (read and clear) |
| rd_data_o | output | NUM_SRC | Status bits returned by the last read |
| rd_vld_o | output | 1 | High for one cycle when `rd_data_o` carries a fresh read |
| irq_n_o | output | 1 | Interrupt line, active low |

## Verification
The sharpest corner case is an event that arrives in the very cycle of a clearing read. A design that clears without re-merging the new event loses it, and the next read returns zero instead of that bit. The bench also latches events while they are masked, disabled or blocked by cell-error-only mode. A design that gated the status bits, instead of only the interrupt line, would return an empty read there. It also switches cell-error-only mode on with every per-source enable off. It then checks that a cell error still interrupts and a non-cell source does not, which catches a mode that only narrows the normal mask instead of replacing it.

// File: rtl/sticky_irq_ctrl_pkg.sv
package sticky_irq_ctrl_pkg;

  typedef enum logic [1:0] {
    IRQ_MODE_OFF    = 2'd0,
    IRQ_MODE_NORMAL = 2'd1,
    IRQ_MODE_CELL   = 2'd2
  } irq_mode_e;

  function automatic irq_mode_e decode_mode(input logic glb_en, input logic cell_only);
    if (!glb_en)        return IRQ_MODE_OFF;
    else if (cell_only) return IRQ_MODE_CELL;
    else                return IRQ_MODE_NORMAL;
  endfunction

endpackage

// File: rtl/irqc_sticky_bank.sv
module irqc_sticky_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic [NUM_SRC-1:0] sticky
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        sticky[i] <= 1'b0;
      else if (clr)
        sticky[i] <= evt[i];              // new event survives the clear
      else
        sticky[i] <= sticky[i] | evt[i];
    end
  end

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import sticky_irq_ctrl_pkg::*;
#(
  parameter int                 NUM_SRC      = 8,
  parameter logic [NUM_SRC-1:0] CELL_ERR_SET = NUM_SRC'(3'b111)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] sticky,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  input  logic               cell_only,
  output logic               irq_n
);

  irq_mode_e          mode;
  logic [NUM_SRC-1:0] sel;
  logic               any_hit;

  always_comb begin
    mode = decode_mode(glb_en, cell_only);
    unique case (mode)
      IRQ_MODE_NORMAL: sel = src_en;
      IRQ_MODE_CELL:   sel = CELL_ERR_SET;
      default:         sel = '0;
    endcase
    any_hit = |(sticky & sel);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~any_hit;
  end

endmodule

// File: rtl/irqc_rd_port.sv
module irqc_rd_port #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [NUM_SRC-1:0] sticky,
  output logic [NUM_SRC-1:0] data,
  output logic               vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= rd;
      if (rd) data <= sticky;
    end
  end

endmodule

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl #(
  parameter int                 NUM_SRC      = 8,
  parameter logic [NUM_SRC-1:0] CELL_ERR_SET = NUM_SRC'(3'b111)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               glb_en_i,
  input  logic               cell_only_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               rd_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               rd_vld_o,
  output logic               irq_n_o
);

  logic [NUM_SRC-1:0] sticky_q;

  irqc_sticky_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt_i),
    .clr    (rd_i),
    .sticky (sticky_q)
  );

  irqc_gate #(.NUM_SRC(NUM_SRC), .CELL_ERR_SET(CELL_ERR_SET)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .sticky    (sticky_q),
    .src_en    (src_en_i),
    .glb_en    (glb_en_i),
    .cell_only (cell_only_i),
    .irq_n     (irq_n_o)
  );

  irqc_rd_port #(.NUM_SRC(NUM_SRC)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (rd_i),
    .sticky (sticky_q),
    .data   (rd_data_o),
    .vld    (rd_vld_o)
  );

endmodule

// File: rtl/sticky_irq_ctrl_chk.sv
module sticky_irq_ctrl_chk #(
  parameter int                 NUM_SRC      = 8,
  parameter logic [NUM_SRC-1:0] CELL_ERR_SET = NUM_SRC'(3'b111)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               glb_en_i,
  input logic               cell_only_i,
  input logic [NUM_SRC-1:0] src_en_i,
  input logic               rd_i,
  input logic [NUM_SRC-1:0] rd_data_o,
  input logic               rd_vld_o,
  input logic               irq_n_o,
  input logic [NUM_SRC-1:0] sticky_q
);

  // R1: reset drives the quiet output state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (irq_n_o && !rd_vld_o && rd_data_o == '0));

  // R2: without a read, every held or newly arriving bit is set afterwards
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> ((sticky_q & $past(sticky_q | evt_i)) == $past(sticky_q | evt_i)));

  // R3: read data equals the pre-edge sticky bits
  p_read_data_r3: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (rd_vld_o && rd_data_o == $past(sticky_q)));

  // R4: after a read only the coincident events remain
  p_read_keep_r4: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (sticky_q == $past(evt_i)));

  // R5: enabled sticky bit in normal mode pulls the line low
  p_irq_low_r5: assert property (@(posedge clk) disable iff (rst)
    (glb_en_i && !cell_only_i && ((sticky_q & src_en_i) != '0)) |=> !irq_n_o);

  // R6: global enable off keeps the line high
  p_glb_off_r6: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> irq_n_o);

  // R8: cell-error-only mode ignores everything outside the cell-error set
  p_cell_only_r8: assert property (@(posedge clk) disable iff (rst)
    (glb_en_i && cell_only_i && ((sticky_q & CELL_ERR_SET) == '0)) |=> irq_n_o);

  // R8: cell errors interrupt in that mode whatever the per-source enables
  p_cell_hit_r8: assert property (@(posedge clk) disable iff (rst)
    (glb_en_i && cell_only_i && ((sticky_q & CELL_ERR_SET) != '0)) |=> !irq_n_o);

endmodule

bind sticky_irq_ctrl sticky_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .CELL_ERR_SET(CELL_ERR_SET)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .glb_en_i(glb_en_i),
  .cell_only_i(cell_only_i), .src_en_i(src_en_i), .rd_i(rd_i),
  .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .irq_n_o(irq_n_o),
  .sticky_q(sticky_q)
);

// File: tb/sticky_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sticky_irq_ctrl_bench;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt = '0;
  logic         glb_en = 1'b0;
  logic         cell_only = 1'b0;
  logic [N-1:0] src_en = '0;
  logic         rd = 1'b0;
  logic [N-1:0] rd_data;
  logic         rd_vld;
  logic         irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [N-1:0] model = '0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  sticky_irq_ctrl #(.NUM_SRC(N)) u_sticky_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .glb_en_i(glb_en),
    .cell_only_i(cell_only), .src_en_i(src_en), .rd_i(rd),
    .rd_data_o(rd_data), .rd_vld_o(rd_vld), .irq_n_o(irq_n)
  );

  task automatic cmp(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); evt = v; model = model | v;
    @(negedge clk); evt = '0;
  endtask

  task automatic do_read(input string tag);
    @(negedge clk); rd = 1'b1;
    exp_q.push_back(model); tag_q.push_back(tag); model = '0;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic read_with_evt(input string tag, input logic [N-1:0] v);
    @(negedge clk); rd = 1'b1; evt = v;
    exp_q.push_back(model); tag_q.push_back(tag); model = v;
    @(negedge clk); rd = 1'b0; evt = '0;
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    cmp(tag, N'(irq_n), N'(exp));
  endtask

  // monitor: compares each returned read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rd_vld) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R3: unexpected read %h expected none", rd_data);
        end else begin
          cmp(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 irq_n", N'(irq_n), N'(1));
    cmp("R1 vld", N'(rd_vld), N'(0));
    cmp("R1 data", rd_data, '0);
    rst = 1'b0;

    // normal mode, all sources enabled
    glb_en = 1'b1; src_en = '1;
    pulse(8'h08);
    chk_irq("R5 low after event", 1'b0);
    do_read("R3 read 08");
    chk_irq("R9 high after clear", 1'b1);

    // masked source still latches, but no interrupt
    src_en = 8'hEF;
    pulse(8'h10);
    chk_irq("R7 masked source", 1'b1);
    do_read("R2 masked latched");

    // global enable off
    src_en = '1; glb_en = 1'b0;
    pulse(8'h01);
    chk_irq("R6 disabled", 1'b1);
    @(negedge clk); glb_en = 1'b1;
    chk_irq("R5 after enable", 1'b0);
    do_read("R2 disabled latched");
    chk_irq("R9 high after read", 1'b1);

    // cell-error-only mode overrides per-source enables
    cell_only = 1'b1; src_en = '0;
    pulse(8'h40);
    chk_irq("R8 non-cell blocked", 1'b1);
    pulse(8'h02);
    chk_irq("R8 cell error interrupts", 1'b0);
    do_read("R8 read 42");
    chk_irq("R9 high after read", 1'b1);
    cell_only = 1'b0; src_en = '1;

    // event coincident with read
    pulse(8'h20);
    read_with_evt("R4 first read", 8'h04);
    chk_irq("R4 kept event interrupts", 1'b0);
    do_read("R4 second read");
    chk_irq("R9 high after read", 1'b1);

    // simultaneous events
    pulse(8'hA5);
    do_read("R10 multi");
    do_read("R3 empty read");

    repeat (3) @(negedge clk);
    cmp("R3 queue drained", N'(exp_q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule